// File: doc/BRIEF.md
# Circular ADC Conversion Sequencer

This block controls a converter by walking through a bank of eight conversion slots. Each slot stores the settings for one conversion: input kind, range, acquisition stretch, alignment, input mode and channel. Software writes the slots while slot-access mode is on. It sets a first and a last slot index and a continuous flag. It starts the block by writing 1 to the run bit. The block waits a fixed power-up time. It then issues one request per slot, counting upward from the first index to the last. The index wraps from 7 back to 0, so the first index may be larger than the last.

For each request, the selected slot's settings appear on `conv_cfg` and the slot number on `slot_idx`. The block then waits for the engine's `conv_done` pulse. In single mode the run bit clears when the last slot's conversion finishes, and the block powers down. In continuous mode the block goes back to the first slot and keeps going until software writes 0 to the run bit. A stop lets the conversion in progress finish and issues no further request.

Top module: `adc_ring_seq`

## Requirements
- R1: A slot write (`cfg_wr_en` high with `cfg_mode` high) stores `cfg_wr_data` into slot `cfg_wr_idx`; with `cfg_mode` low the write is ignored. During a request, `conv_cfg` shows the stored word of slot `slot_idx`. Word layout: bits 3:0 channel, bit 4 differential, bit 5 left-aligned, bit 6 extended acquisition, bits 8:7 range, bit 9 temperature select.
- R2: Slots are requested in the order first, first+1, … up to last, counting modulo 8. For example, first 5 and last 1 give 5, 6, 7, 0, 1.
- R3: When first equals last, a run in single mode issues exactly one request.
- R4: In single mode, `run_bit` and `powered` go low in the cycle after `conv_done` is sampled for the last slot.
- R5: In continuous mode, the last slot is followed by the first slot, and `run_bit` stays high.
- R6: Writing 0 to the run bit clears `run_bit` at once. The conversion in flight still completes, no further `conv_req` follows, and `powered` then drops.
- R7: Writing 1 to the run bit is ignored while `run_bit` is high or while the block is still powered. It does not restart the order and does not start a new power-up.
- R8: The first `conv_req` of a run comes exactly ADC_DIV*WARM_TICKS clocks (80 by default) after the edge that accepted the run write.
- R9: `conv_req` is a one-cycle pulse, after which the block waits for `conv_done`. A `conv_done` pulse at any other time has no effect.
- R10: `seq_end` pulses for one cycle, in the cycle after `conv_done` is sampled for the last slot's conversion.
- R11: After reset, `run_bit`, `powered`, `conv_req` and `seq_end` are 0, `slot_idx` is 0, and all slots hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Slot-access mode; slot writes count only when high |
| cfg_wr_en | input | 1 | Slot write strobe |
| cfg_wr_idx | input | 3 | Slot index of the write |
| cfg_wr_data | input | 10 | Slot settings word |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_run | input | 1 | Run bit value written |
| ctl_wr_cont | input | 1 | Continuous flag value written |
| ctl_wr_first | input | 3 | First slot index written |
| ctl_wr_last | input | 3 | Last slot index written |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| conv_req | output | 1 | One-cycle conversion request |
| conv_cfg | output | 10 | Settings of the current slot |
| slot_idx | output | 3 | Current slot index |
| seq_end | output | 1 | Pulse when the last slot's conversion completes |
| run_bit | output | 1 | Run bit readback |
| powered | output | 1 | High from run acceptance until shutdown |

## Verification
The first request is due exactly 80 clocks after the edge that accepted the run write. The bench counts falling edges from that write until `conv_req` is seen and compares the count with 80. Each later request appears in the cycle after `conv_done` is sampled. `seq_end`, the clearing of `run_bit` and the drop of `powered` all land in that same cycle. The bench's engine model therefore logs the slot and settings at the falling edge where `conv_req` is high. It answers a fixed five cycles later, and the main flow compares the log once `powered` has dropped. A stop is always issued while the engine model is holding off its answer. This makes the number of requests expected after the stop exact.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    parameter int NSLOT = 8;
    parameter int IDX_W = $clog2(NSLOT);
    parameter int CH_W  = 4;

    typedef struct packed {
        logic            temp_sel;
        logic [1:0]      fs_range;
        logic            ext_acq;
        logic            left_just;
        logic            diff_in;
        logic [CH_W-1:0] chan;
    } slot_cfg_t;

    parameter int CFG_W = $bits(slot_cfg_t);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WARM,
        ST_ISSUE,
        ST_WAIT
    } seq_st_e;
endpackage

// File: rtl/adcseq_cfg_bank.sv
module adcseq_cfg_bank
    import adcseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_cfg_t        wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_cfg_t        rd_data
);
    slot_cfg_t bank_d [NSLOT];
    slot_cfg_t bank_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            bank_d[g] = bank_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                bank_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= bank_d[g];
            end
        end
    end

    assign rd_data = bank_q[rd_idx];
endmodule

// File: rtl/adcseq_warm_timer.sv
module adcseq_warm_timer #(
    parameter int CYC = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/adcseq_step.sv
module adcseq_step
    import adcseq_pkg::*;
(
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] nxt,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NSLOT - 1);

    always_comb begin
        if (cur == TOP) begin
            nxt = '0;
        end else begin
            nxt = cur + IDX_W'(1);
        end
        at_last = (cur == last);
    end
endmodule

// File: rtl/adc_ring_seq.sv
module adc_ring_seq
    import adcseq_pkg::*;
#(
    parameter int ADC_DIV    = 4,
    parameter int WARM_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_wr_en,
    input  logic [IDX_W-1:0] cfg_wr_idx,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             ctl_wr_en,
    input  logic             ctl_wr_run,
    input  logic             ctl_wr_cont,
    input  logic [IDX_W-1:0] ctl_wr_first,
    input  logic [IDX_W-1:0] ctl_wr_last,
    input  logic             conv_done,
    output logic             conv_req,
    output logic [CFG_W-1:0] conv_cfg,
    output logic [IDX_W-1:0] slot_idx,
    output logic             seq_end,
    output logic             run_bit,
    output logic             powered
);
    localparam int WARM_CYC = ADC_DIV * WARM_TICKS;

    typedef struct packed {
        seq_st_e          state;
        logic             run;
        logic             cont;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] slot;
        logic             fin;
    } seq_regs_t;

    seq_regs_t        st_d, st_q;
    logic             tmr_clr, tmr_en, tmr_done;
    logic [IDX_W-1:0] slot_nxt;
    logic             slot_at_last;
    slot_cfg_t        cur_cfg;
    logic             warming;

    adcseq_cfg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en && cfg_mode),
        .wr_idx  (cfg_wr_idx),
        .wr_data (slot_cfg_t'(cfg_wr_data)),
        .rd_idx  (st_q.slot),
        .rd_data (cur_cfg)
    );

    adcseq_warm_timer #(.CYC(WARM_CYC)) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .done  (tmr_done)
    );

    adcseq_step u_step (
        .cur     (st_q.slot),
        .last    (st_q.last),
        .nxt     (slot_nxt),
        .at_last (slot_at_last)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        tmr_clr  = 1'b0;
        tmr_en   = 1'b0;

        if (ctl_wr_en) begin
            st_d.cont  = ctl_wr_cont;
            st_d.first = ctl_wr_first;
            st_d.last  = ctl_wr_last;
            if (!ctl_wr_run) begin
                st_d.run = 1'b0;
            end else if (!st_q.run && (st_q.state == ST_OFF)) begin
                st_d.run   = 1'b1;
                st_d.state = ST_WARM;
                tmr_clr    = 1'b1;
            end
        end

        case (st_q.state)
            ST_WARM: begin
                tmr_en = 1'b1;
                if (!st_d.run) begin
                    st_d.state = ST_OFF;
                end else if (tmr_done) begin
                    st_d.state = ST_ISSUE;
                    st_d.slot  = st_q.first;
                end
            end
            ST_ISSUE: begin
                st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (slot_at_last) begin
                        st_d.fin = 1'b1;
                        if (!st_q.cont) begin
                            st_d.run   = 1'b0;
                            st_d.state = ST_OFF;
                        end else if (!st_d.run) begin
                            st_d.state = ST_OFF;
                        end else begin
                            st_d.slot  = st_q.first;
                            st_d.state = ST_ISSUE;
                        end
                    end else if (!st_d.run) begin
                        st_d.state = ST_OFF;
                    end else begin
                        st_d.slot  = slot_nxt;
                        st_d.state = ST_ISSUE;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_OFF, run: 1'b0, cont: 1'b0, first: '0,
                      last: '0, slot: '0, fin: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_req = (st_q.state == ST_ISSUE);
    assign conv_cfg = CFG_W'(cur_cfg);
    assign slot_idx = st_q.slot;
    assign seq_end  = st_q.fin;
    assign run_bit  = st_q.run;
    assign powered  = (st_q.state != ST_OFF);
    assign warming  = (st_q.state == ST_WARM);
endmodule

module adcseq_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_req,
    input logic conv_done,
    input logic seq_end,
    input logic run_bit,
    input logic powered,
    input logic ctl_wr_en,
    input logic ctl_wr_run,
    input logic warming,
    input logic cont
);
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    a_r9_req_powered: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> powered);

    a_r6_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> run_bit);

    a_r11_run_implies_power: assert property (@(posedge clk) disable iff (!rst_n)
        run_bit |-> powered);

    a_r10_end_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |-> $past(conv_done));

    a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |=> !seq_end);

    a_r4_single_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && !$past(cont)) |-> (!run_bit && !powered));

    a_r7_no_rewarm: assert property (@(posedge clk) disable iff (!rst_n)
        (run_bit && !warming && ctl_wr_en && ctl_wr_run) |=> !warming);
endmodule

bind adc_ring_seq adcseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_req   (conv_req),
    .conv_done  (conv_done),
    .seq_end    (seq_end),
    .run_bit    (run_bit),
    .powered    (powered),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_run (ctl_wr_run),
    .warming    (warming),
    .cont       (st_q.cont)
);

// File: tb/adc_ring_seq_bench.sv
module adc_ring_seq_bench;
    localparam int LAT  = 5;
    localparam int WARM = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0, cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_idx = '0;
    logic [9:0] cfg_wr_data = '0;
    logic       ctl_wr_en = 1'b0, ctl_wr_run = 1'b0, ctl_wr_cont = 1'b0;
    logic [2:0] ctl_wr_first = '0, ctl_wr_last = '0;
    logic       conv_done;
    logic       conv_req, seq_end, run_bit, powered;
    logic [9:0] conv_cfg;
    logic [2:0] slot_idx;

    int nchk = 0, nfail = 0;
    int log_n = 0, end_n = 0, cfg_err = 0;
    logic [2:0] log_slot [64];
    logic [9:0] model [8];
    bit finished = 0;

    always #4 clk = ~clk;

    adc_ring_seq u_adc_ring_seq (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data), .ctl_wr_en(ctl_wr_en),
        .ctl_wr_run(ctl_wr_run), .ctl_wr_cont(ctl_wr_cont),
        .ctl_wr_first(ctl_wr_first), .ctl_wr_last(ctl_wr_last),
        .conv_done(conv_done), .conv_req(conv_req), .conv_cfg(conv_cfg),
        .slot_idx(slot_idx), .seq_end(seq_end), .run_bit(run_bit), .powered(powered)
    );

    function automatic int seq_len(input int f, input int l);
        return ((l - f) & 7) + 1;
    endfunction

    function automatic int seq_slot(input int f, input int k);
        return (f + k) % 8;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // engine model: log each request, answer LAT cycles later
    initial begin
        conv_done = 1'b0;
        @(negedge clk);
        forever begin
            if (rst_n && conv_req) begin
                if (log_n < 64) log_slot[log_n] = slot_idx;
                log_n++;
                if (conv_cfg !== model[slot_idx]) cfg_err++;
                repeat (LAT - 1) @(negedge clk);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (seq_end) end_n++;
    end

    task automatic cfg_write(input bit mode, input int idx, input logic [9:0] d);
        cfg_mode = mode; cfg_wr_en = 1'b1; cfg_wr_idx = 3'(idx); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_mode = 1'b0;
        if (mode) model[idx] = d;
    endtask

    task automatic ctl_write(input bit run, input bit cont, input int f, input int l);
        ctl_wr_en = 1'b1; ctl_wr_run = run; ctl_wr_cont = cont;
        ctl_wr_first = 3'(f); ctl_wr_last = 3'(l);
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (powered) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_single(input int f, input int l, input string req);
        int lat = 0;
        bit ok;
        log_n = 0; end_n = 0; cfg_err = 0;
        ctl_write(1'b1, 1'b0, f, l);
        while (!conv_req) begin
            @(negedge clk);
            lat++;
        end
        check(lat == WARM, "R8 power-up latency", lat, WARM);
        wait_idle();
        ok = (log_n == seq_len(f, l));
        for (int k = 0; k < seq_len(f, l) && k < log_n; k++)
            if (int'(log_slot[k]) != seq_slot(f, k)) ok = 0;
        check(ok, req, log_n, seq_len(f, l));
        check(end_n == 1, "R10 one end pulse", end_n, 1);
        check(run_bit == 1'b0, "R4 run cleared", run_bit, 0);
        check(cfg_err == 0, "R1 slot settings", cfg_err, 0);
    endtask

    initial begin
        int lg;
        bit ok;
        void'($urandom(32'h5EC0_0A7D));
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check({run_bit, powered, conv_req, seq_end} == 4'b0, "R11 reset flags",
              {run_bit, powered, conv_req, seq_end}, 0);
        check(slot_idx == 3'd0, "R11 reset slot", slot_idx, 0);

        // R9 stray done while idle
        conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        repeat (3) @(negedge clk);
        check(!powered && !run_bit && end_n == 0, "R9 stray done ignored", powered, 0);

        // R1 slot writes
        for (int i = 0; i < 8; i++) cfg_write(1'b1, i, 10'($urandom));
        cfg_write(1'b0, 2, ~model[2]);

        run_single(1, 5, "R2 order 1..5");
        run_single(5, 1, "R2 wrap order 5..1");
        run_single(3, 3, "R3 single conversion");
        run_single(2, 2, "R1 ignored write in access mode off");

        // R5/R6 continuous then stop
        log_n = 0; end_n = 0; cfg_err = 0;
        ctl_write(1'b1, 1'b1, 6, 0);
        wait (log_n == 7);
        @(negedge clk);
        check(run_bit == 1'b1, "R5 run stays set", run_bit, 1);
        ctl_write(1'b0, 1'b1, 6, 0);
        check(run_bit == 1'b0 && powered, "R6 run clears, drain", run_bit, 0);
        lg = log_n;
        ctl_write(1'b1, 1'b1, 6, 0);   // R7 write 1 while draining
        wait_idle();
        repeat (WARM + 20) @(negedge clk);
        check(log_n == lg && lg == 7, "R6 no request after stop", log_n, 7);
        check(!powered && !run_bit, "R7 ignored while draining", powered, 0);
        ok = 1;
        for (int k = 0; k < 7; k++)
            if (int'(log_slot[k]) != seq_slot(6, k % 3)) ok = 0;
        check(ok, "R5 restart at first", ok, 1);
        check(end_n == 2, "R10 end pulses continuous", end_n, 2);
        check(cfg_err == 0, "R1 slot settings continuous", cfg_err, 0);

        // R7 write 1 while running
        log_n = 0; end_n = 0;
        ctl_write(1'b1, 1'b0, 0, 7);
        wait (log_n == 3);
        @(negedge clk);
        ctl_write(1'b1, 1'b0, 0, 7);
        wait_idle();
        ok = (log_n == 8);
        for (int k = 0; k < 8 && k < log_n; k++)
            if (int'(log_slot[k]) != k) ok = 0;
        check(ok, "R7 rewrite ignored", log_n, 8);
        check(end_n == 1, "R7 single end pulse", end_n, 1);

        // random ranges
        for (int i = 0; i < 8; i++) begin
            int f = int'($urandom % 8);
            int l = int'($urandom % 8);
            if (i == 3) cfg_write(1'b1, f, 10'($urandom));
            run_single(f, l, "R2 random range");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule